// File: doc/BRIEF.md
# SPI Master Serial-Clock and Wait-State Generator

This block paces the serial clock of an SPI master and places idle clock periods between words. It keeps its own configuration fields, each loaded through a per-field write strobe: a divider-mode select, a power-of-two divider exponent, a linear divider value, an inter-word wait count and a dual-I/O turnaround wait count. The divider gives the SCLK period `P` in source-clock cycles. With the select at 0, `P = 2^n`. With the select at 1, `P = 2*(n+1)`.

A shift engine holds `word_req` high when it has a word to send, and sets `word_dual` if that word opens a dual-I/O phase. The block answers with a one-cycle `word_ready` strobe. It then issues one `sclk_pulse` per SCLK period until the shifter raises `word_done`. The block does not pulse `sclk_pulse` during wait periods, so the serial clock stays at its idle level there. After a word the inter-word wait runs first. If the next word is dual, the turnaround wait follows. The divider setting is captured only when a word is accepted.

Top module: `spi_clkgen`

## Requirements
- R1: After reset, `word_ready` and `sclk_pulse` are 0. The mode select resets to 0 (power-of-two), the exponent to 0, the linear value to 2, and both wait counts to 0.
- R2: With the select at 0 and exponent `n`, consecutive `sclk_pulse` strobes inside a word are `2^n` source cycles apart.
- R3: With the select at 1 and linear value `n`, consecutive `sclk_pulse` strobes inside a word are `2*(n+1)` source cycles apart.
- R4: `word_ready` is high for exactly one cycle per word. The first `sclk_pulse` of the word comes in the next cycle. No `sclk_pulse` appears outside a word, and none appears on the cycle `word_done` is sampled.
- R5: If `word_done` is sampled at clock edge `e` and the inter-word count is `N`, the next `word_ready` rises at edge `e + N*P + 1`. Here `P` is the period of the finished word, and `word_req` is held high.
- R6: A word accepted with `word_dual=1` and a turnaround count `T` that is not zero gets `T*P` extra cycles before its `word_ready`. Here `P` is the period of the new word.
- R7: When both waits apply, the inter-word wait is served first and the turnaround wait second, giving a total of `N*Pold + T*Pnew` added cycles.
- R8: A turnaround-count write is ignored while `xchg_busy=1`. Writes to the other fields still take effect.
- R9: A divider write made during a word changes neither that word's pulse spacing nor the wait that follows it. The new setting applies from the next accepted word.
- R10: While `master_en=0`, a pending `word_req` is not accepted: no `word_ready` and no `sclk_pulse` appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master-mode enable; words are accepted only when high |
| xchg_busy | input | 1 | Exchange in progress; locks the turnaround field |
| cfg_wdata | input | 16 | Write data, each field right-aligned (bit 0 upward) |
| cfg_we_sel | input | 1 | Write strobe for the mode select (cfg_wdata[0]) |
| cfg_we_pow | input | 1 | Write strobe for the power-of-two exponent (cfg_wdata[3:0]) |
| cfg_we_lin | input | 1 | Write strobe for the linear divider value (cfg_wdata[7:0]) |
| cfg_we_gap | input | 1 | Write strobe for the inter-word wait count (cfg_wdata[15:0]) |
| cfg_we_turn | input | 1 | Write strobe for the turnaround wait count (cfg_wdata[3:0]) |
| word_req | input | 1 | Shifter has a word pending |
| word_dual | input | 1 | Pending word starts a dual-I/O phase |
| word_done | input | 1 | Shifter has finished the current word |
| word_ready | output | 1 | One-cycle strobe: the shifter may start the word |
| sclk_pulse | output | 1 | One-cycle strobe, once per SCLK period during a word |

## Verification
A corrupted period counter or latched period shows up at the first in-word pulse interval after the fault, within one SCLK period, as a wrong spacing. A wrong wait counter or state bit moves the next `word_ready` by whole SCLK periods. It can also produce a pulse or a ready strobe outside a word, and the bench flags that on the cycle it happens. A broken write lock or a divider taken mid-word does not show until the following word. There it appears as a dual-word delay or a pulse spacing that is off by a predictable amount.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2,
        ST_TURN = 2'd3
    } clk_state_e;
endpackage

// File: rtl/spi_clkgen_cfg.sv
module spi_clkgen_cfg #(
    parameter int POW_W   = 4,
    parameter int LIN_W   = 8,
    parameter int GAP_W   = 16,
    parameter int TURN_W  = 4,
    parameter int LIN_RST = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xchg_busy,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we_sel,
    input  logic              we_pow,
    input  logic              we_lin,
    input  logic              we_gap,
    input  logic              we_turn,
    output logic              sel_o,
    output logic [POW_W-1:0]  pow_o,
    output logic [LIN_W-1:0]  lin_o,
    output logic [GAP_W-1:0]  gap_o,
    output logic [TURN_W-1:0] turn_o
);
    typedef struct packed {
        logic              sel;
        logic [POW_W-1:0]  pow;
        logic [LIN_W-1:0]  lin;
        logic [GAP_W-1:0]  gap;
        logic [TURN_W-1:0] turn;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_sel) cfg_d.sel = wdata[0];
        if (we_pow) cfg_d.pow = wdata[POW_W-1:0];
        if (we_lin) cfg_d.lin = wdata[LIN_W-1:0];
        if (we_gap) cfg_d.gap = wdata[GAP_W-1:0];
        // turnaround field is locked while an exchange runs
        if (we_turn && !xchg_busy) cfg_d.turn = wdata[TURN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel  <= 1'b0;
            cfg_q.pow  <= '0;
            cfg_q.lin  <= LIN_W'(LIN_RST);
            cfg_q.gap  <= '0;
            cfg_q.turn <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_o  = cfg_q.sel;
    assign pow_o  = cfg_q.pow;
    assign lin_o  = cfg_q.lin;
    assign gap_o  = cfg_q.gap;
    assign turn_o = cfg_q.turn;

    p_turn_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_busy |=> $stable(cfg_q.turn));
endmodule

// File: rtl/spi_clkgen_div.sv
module spi_clkgen_div #(
    parameter int POW_W = 4,
    parameter int LIN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             sel,
    input  logic [POW_W-1:0] pow,
    input  logic [LIN_W-1:0] lin,
    output logic [CNT_W-1:0] period_m1
);
    logic [CNT_W-1:0] pow_m1;
    logic [CNT_W-1:0] lin_m1;

    always_comb begin
        // 2^n - 1 for the power-of-two formula
        pow_m1 = (CNT_W'(1) << pow) - CNT_W'(1);
        // 2*(n+1) - 1 = 2n + 1 for the linear formula
        lin_m1 = CNT_W'({lin, 1'b1});
        period_m1 = sel ? lin_m1 : pow_m1;
    end
endmodule

// File: rtl/spi_clkgen_seq.sv
module spi_clkgen_seq
    import spi_clkgen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 16,
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              word_req,
    input  logic              word_dual,
    input  logic              word_done,
    input  logic [CNT_W-1:0]  period_m1,
    input  logic [GAP_W-1:0]  gap_cnt,
    input  logic [TURN_W-1:0] turn_cnt,
    output logic              ready_o,
    output logic              pulse_o
);
    localparam int WCNT_W = (GAP_W > TURN_W) ? GAP_W : TURN_W;

    typedef struct packed {
        clk_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [WCNT_W-1:0] wcnt;
        logic [CNT_W-1:0]  per;
        logic              ready;
        logic              pulse;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        s_d.pulse = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (master_en && word_req) begin
                    s_d.per = period_m1;      // divider captured at word boundary
                    if (word_dual && (turn_cnt != '0)) begin
                        s_d.state = ST_TURN;
                        s_d.cnt   = period_m1;
                        s_d.wcnt  = WCNT_W'(turn_cnt);
                    end else begin
                        s_d.state = ST_RUN;
                        s_d.ready = 1'b1;
                        s_d.cnt   = '0;
                    end
                end
            end
            ST_RUN: begin
                if (word_done) begin
                    if (gap_cnt != '0) begin
                        s_d.state = ST_GAP;
                        s_d.cnt   = s_q.per;
                        s_d.wcnt  = WCNT_W'(gap_cnt);
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end else begin
                    s_d.pulse = (s_q.cnt == '0);
                    s_d.cnt   = (s_q.cnt == '0) ? s_q.per : s_q.cnt - CNT_W'(1);
                end
            end
            ST_GAP, ST_TURN: begin
                if (s_q.cnt == '0) begin
                    if (s_q.wcnt == WCNT_W'(1)) begin
                        if (s_q.state == ST_GAP) begin
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.state = ST_RUN;
                            s_d.ready = 1'b1;
                            s_d.cnt   = '0;
                        end
                    end else begin
                        s_d.wcnt = s_q.wcnt - WCNT_W'(1);
                        s_d.cnt  = s_q.per;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.wcnt  <= '0;
            s_q.per   <= '0;
            s_q.ready <= 1'b0;
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = s_q.ready;
    assign pulse_o = s_q.pulse;

    p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |=> !s_q.ready);
    p_pulse_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ready && !word_done) |=> s_q.pulse);
    p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_GAP || s_q.state == ST_TURN) |-> (!s_q.pulse && !s_q.ready));
    p_period_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE) |=> $stable(s_q.per));
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE && !master_en) |=> (!s_q.ready && s_q.state == ST_IDLE));
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int POW_W   = 4,
    parameter int LIN_W   = 8,
    parameter int GAP_W   = 16,
    parameter int TURN_W  = 4,
    parameter int LIN_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             xchg_busy,
    input  logic [GAP_W-1:0] cfg_wdata,
    input  logic             cfg_we_sel,
    input  logic             cfg_we_pow,
    input  logic             cfg_we_lin,
    input  logic             cfg_we_gap,
    input  logic             cfg_we_turn,
    input  logic             word_req,
    input  logic             word_dual,
    input  logic             word_done,
    output logic             word_ready,
    output logic             sclk_pulse
);
    localparam int POW_BITS = 1 << POW_W;
    localparam int CNT_W    = (POW_BITS > LIN_W + 1) ? POW_BITS : LIN_W + 1;

    logic              sel;
    logic [POW_W-1:0]  pow;
    logic [LIN_W-1:0]  lin;
    logic [GAP_W-1:0]  gap;
    logic [TURN_W-1:0] turn;
    logic [CNT_W-1:0]  period_m1;

    spi_clkgen_cfg #(
        .POW_W(POW_W), .LIN_W(LIN_W), .GAP_W(GAP_W), .TURN_W(TURN_W),
        .LIN_RST(LIN_RST), .DATA_W(GAP_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .xchg_busy(xchg_busy), .wdata(cfg_wdata),
        .we_sel(cfg_we_sel), .we_pow(cfg_we_pow), .we_lin(cfg_we_lin),
        .we_gap(cfg_we_gap), .we_turn(cfg_we_turn),
        .sel_o(sel), .pow_o(pow), .lin_o(lin), .gap_o(gap), .turn_o(turn)
    );

    spi_clkgen_div #(.POW_W(POW_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_div (
        .sel(sel), .pow(pow), .lin(lin), .period_m1(period_m1)
    );

    spi_clkgen_seq #(.CNT_W(CNT_W), .GAP_W(GAP_W), .TURN_W(TURN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .word_req(word_req), .word_dual(word_dual), .word_done(word_done),
        .period_m1(period_m1), .gap_cnt(gap), .turn_cnt(turn),
        .ready_o(word_ready), .pulse_o(sclk_pulse)
    );
endmodule

// File: tb/tb_spi_clkgen.sv
module tb_spi_clkgen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b1, xchg_busy = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic cfg_we_sel = 0, cfg_we_pow = 0, cfg_we_lin = 0, cfg_we_gap = 0, cfg_we_turn = 0;
    logic word_req = 0, word_dual = 0, word_done = 0;
    logic word_ready, sclk_pulse;

    always #10 clk = ~clk;   // 50 MHz

    spi_clkgen dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .xchg_busy(xchg_busy),
        .cfg_wdata(cfg_wdata), .cfg_we_sel(cfg_we_sel), .cfg_we_pow(cfg_we_pow),
        .cfg_we_lin(cfg_we_lin), .cfg_we_gap(cfg_we_gap), .cfg_we_turn(cfg_we_turn),
        .word_req(word_req), .word_dual(word_dual), .word_done(word_done),
        .word_ready(word_ready), .sclk_pulse(sclk_pulse)
    );

    typedef struct {
        bit    dual;
        bit    chk;
        int    gap;
        int    per;
        int    np;
        string tag;
    } word_t;

    word_t q[$];
    word_t cur;
    int checks = 0, errors = 0;
    int cyc = 0, last_cyc = 0, done_cyc = 0, pcount = 0;
    int ready_cnt = 0, pulse_total = 0, started = 0;
    bit active = 0, finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: pushes expected words into the scoreboard and raises the request
    task automatic push(input bit dual, input bit c, input int gap, input int per,
                        input int np, input string tag);
        word_t w;
        w.dual = dual; w.chk = c; w.gap = gap; w.per = per; w.np = np; w.tag = tag;
        @(posedge clk); #1;
        q.push_back(w);
        word_req  = 1'b1;
        word_dual = active ? q[1].dual : q[0].dual;
    endtask

    task automatic wr(input int field, input int val);
        @(posedge clk); #1;
        cfg_wdata = 16'(val);
        case (field)
            0: cfg_we_sel = 1;
            1: cfg_we_pow = 1;
            2: cfg_we_lin = 1;
            3: cfg_we_gap = 1;
            default: cfg_we_turn = 1;
        endcase
        @(posedge clk); #1;
        {cfg_we_sel, cfg_we_pow, cfg_we_lin, cfg_we_gap, cfg_we_turn} = '0;
    endtask

    task automatic drain();
        wait (q.size() == 0 && !active);
        repeat (150) @(posedge clk);
    endtask

    // monitor / shifter model: pops and compares as the design produces results
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (word_done) word_done = 1'b0;
            if (sclk_pulse) pulse_total++;
            if (word_ready) ready_cnt++;
            if (active) begin
                if (word_ready) chk(0, "R4 second ready inside a word", 1, 0);
                if (sclk_pulse) begin
                    if (pcount == 0)
                        chk(cyc - last_cyc == 1, "R4 first pulse after ready", cyc - last_cyc, 1);
                    else
                        chk(cyc - last_cyc == cur.per, {cur.tag, " pulse spacing"}, cyc - last_cyc, cur.per);
                    pcount++;
                    last_cyc = cyc;
                    if (pcount == cur.np) begin
                        word_done = 1'b1;
                        done_cyc  = cyc;
                        void'(q.pop_front());
                        active    = 0;
                        word_req  = (q.size() > 0);
                        word_dual = (q.size() > 0) ? q[0].dual : 1'b0;
                    end
                end
            end else begin
                if (sclk_pulse) chk(0, "R4 pulse outside a word", 1, 0);
                if (word_ready) begin
                    if (q.size() == 0) chk(0, "R4 ready with nothing pending", 1, 0);
                    else begin
                        cur = q[0];
                        active = 1; pcount = 0; last_cyc = cyc; started++;
                        if (cur.chk)
                            chk(cyc - done_cyc == cur.gap, {cur.tag, " done-to-ready"}, cyc - done_cyc, cur.gap);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rc, pc, st;
        repeat (3) @(negedge clk);
        chk(word_ready == 0, "R1 ready in reset", word_ready, 0);
        chk(sclk_pulse == 0, "R1 pulse in reset", sclk_pulse, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_ready == 0 && sclk_pulse == 0, "R1 idle after reset", word_ready, 0);

        // R1 defaults: power-of-two mode, exponent 0 -> P = 1, no waits (R2, R5 N=0)
        push(0, 0, 0, 1, 3, "R1 default P=1");
        push(0, 1, 2, 1, 3, "R1 R2 default P=1");
        drain();

        // R1 linear default 2 -> P = 6 (R3)
        wr(0, 1);
        push(0, 0, 0, 6, 3, "R1 R3 lin default");
        push(0, 1, 2, 6, 3, "R3 lin default P=6");
        drain();

        // R2 exponent 3 -> P = 8, R5 N = 2 -> gap 2*8+2
        wr(0, 0); wr(1, 3); wr(3, 2);
        push(0, 0, 0, 8, 3, "R2 pow P=8");
        push(0, 1, 18, 8, 3, "R5 gap N=2 P=8");
        drain();

        // R3 lin 4 -> P = 10, R6 turnaround T = 3
        wr(0, 1); wr(2, 4); wr(3, 0); wr(4, 3);
        push(1, 0, 0, 10, 2, "R6 first dual");
        push(0, 1, 2, 10, 2, "R6 non-dual no wait");
        push(1, 1, 32, 10, 2, "R6 dual T=3 P=10");
        drain();

        // R7 both waits: lin 1 -> P = 4, N = 2, T = 1
        wr(2, 1); wr(3, 2); wr(4, 1);
        push(0, 0, 0, 4, 2, "R7 lead");
        push(1, 1, 14, 4, 2, "R7 gap then turn");
        push(0, 1, 10, 4, 2, "R7 gap only");
        drain();

        // R8 turnaround locked while busy, gap still writable
        xchg_busy = 1'b1;
        wr(4, 5); wr(3, 1);
        xchg_busy = 1'b0;
        push(0, 0, 0, 4, 2, "R8 lead");
        push(1, 1, 10, 4, 2, "R8 locked turn T=1");
        drain();

        // R9 divider change mid-word: old P=4 for rest of word and its gap, new P=8 next
        wr(4, 0);
        st = started;
        push(0, 0, 0, 4, 12, "R9 old divider");
        wait (started == st + 1);
        wr(2, 3);
        push(0, 1, 6, 8, 3, "R9 new divider");
        drain();

        // R10 master mode off: request not accepted
        @(posedge clk); #1;
        master_en = 1'b0;
        rc = ready_cnt; pc = pulse_total;
        push(0, 0, 0, 8, 2, "R10 held word");
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(ready_cnt == rc, "R10 ready while disabled", ready_cnt - rc, 0);
        chk(pulse_total == pc, "R10 pulse while disabled", pulse_total - pc, 0);
        @(posedge clk); #1;
        master_en = 1'b1;
        drain();
        chk(ready_cnt == rc + 1, "R10 accepted after enable", ready_cnt - rc, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule